// File: doc/BRIEF.md
# Reservation Station Bank with Result-Bus Snooping

This block is a small pool of waiting slots that sits in front of one functional unit in a core that schedules by dataflow. An issued operation arrives with an operation code, a destination tag and, for each of its two operands, either a ready value or the tag of the operation that will produce that value. Tag zero is reserved to mean "value present". The operation then waits in a free slot until both of its operands are known.

Each cycle the bank watches one result broadcast bus. Any waiting operand whose producer tag equals the broadcast tag copies the broadcast value and marks itself ready. One broadcast may wake several slots, or both operands of one slot. Among the slots whose operands are both ready, the bank offers the oldest one to the functional unit through a valid/ready handshake. The slot is released on the cycle the unit accepts it. A flush empties the whole bank at once.

Top module: `rsBank`

## Requirements
- R1: After reset, and on the cycle after `flush` is high, no slot is occupied: `issueFull` is 0 and `dispValid` is 0, and a later broadcast of a dropped operation's producer tag dispatches nothing.
- R2: An operand issued with tag 0 is taken as the issued value. An operation issued with both tags 0 is offered on the dispatch port from the cycle after issue, carrying its opcode, operand A value, operand B value and destination tag.
- R3: When `busValid` is high and `busTag` is nonzero and equals a slot's waiting tag for an operand, that operand takes `busVal` and its tag becomes 0. A slot stays unready while any operand tag is nonzero.
- R4: One broadcast wakes every matching operand in the same cycle, across several slots and for both operands of one slot.
- R5: A broadcast whose tag matches no waiting operand leaves the waiting slots unready and changes nothing on the dispatch port.
- R6: An issue with `issueFull` low occupies exactly one free slot. `issueFull` is 1 when all ENTRIES slots are occupied, and an issue offered while it is 1 is dropped.
- R7: When several slots are ready, the one issued earliest is offered first, whatever the order in which the slots became ready.
- R8: An operand issued in the same cycle as a broadcast of its producer tag captures the broadcast value.
- R9: A slot is released on the clock edge where `dispValid` and `dispReady` are both high, so a full bank is no longer full on the following cycle. An offer that is not accepted stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop every occupied slot |
| issueValid | input | 1 | Issue request |
| issueOp | input | OP_W | Operation code of the issued operation |
| issueTagA | input | TAG_W | Producer tag of operand A, 0 if value given |
| issueValA | input | DATA_W | Value of operand A when its tag is 0 |
| issueTagB | input | TAG_W | Producer tag of operand B, 0 if value given |
| issueValB | input | DATA_W | Value of operand B when its tag is 0 |
| issueDest | input | TAG_W | Destination tag of the issued operation |
| issueFull | output | 1 | All slots occupied; issue is dropped |
| busValid | input | 1 | Result broadcast valid |
| busTag | input | TAG_W | Tag of the broadcast result |
| busVal | input | DATA_W | Broadcast result value |
| dispValid | output | 1 | A ready operation is offered |
| dispReady | input | 1 | Functional unit accepts the offer |
| dispOp | output | OP_W | Offered operation code |
| dispValA | output | DATA_W | Offered operand A |
| dispValB | output | DATA_W | Offered operand B |
| dispDest | output | TAG_W | Offered destination tag |

## Verification
Issue and broadcast can land in the same cycle, and the interesting case is an operand that is being written into a slot while its producer's result passes on the bus. The bench drives an issue whose tag equals the broadcast tag in that very cycle, then opens the dispatch port and judges, through the scoreboard, that the offered operand carries the broadcast value and not the stale issued one. Dispatch and issue also overlap while the bank drains a full state, and there the bench checks that `issueFull` drops on the cycle after the first acceptance.

// File: rtl/rsPkg.sv
package rsPkg;
  localparam int RS_MAX   = 16;
  localparam int RS_IDX_W = $clog2(RS_MAX);

  typedef struct packed {
    logic [RS_MAX-1:0]   issueOh;
    logic [RS_IDX_W-1:0] dispIdx;
  } rsCtrlT;
endpackage

// File: rtl/rsCtrl.sv
module rsCtrl
  import rsPkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic               issueValid,
  input  logic               dispReady,
  input  logic [ENTRIES-1:0] readyVec,
  output logic               issueFull,
  output logic               dispValid,
  output rsCtrlT             ctrlOut
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int AGE_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] busy, busyNext;
  logic [AGE_W-1:0]   age [ENTRIES];
  logic [AGE_W-1:0]   ageNext [ENTRIES];
  logic [IDX_W-1:0]   freeIdx, bestIdx;
  logic [AGE_W-1:0]   bestAge;
  logic               bestFound, doIssue, fire;

  always_comb begin
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!busy[i]) freeIdx = IDX_W'(i);
    end
  end

  always_comb begin
    bestFound = 1'b0;
    bestIdx   = '0;
    bestAge   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (busy[i] && readyVec[i] && (!bestFound || age[i] > bestAge)) begin
        bestFound = 1'b1;
        bestIdx   = IDX_W'(i);
        bestAge   = age[i];
      end
    end
  end

  assign issueFull = &busy;
  assign doIssue   = issueValid && !issueFull && !flush;
  assign dispValid = bestFound;
  assign fire      = bestFound && dispReady && !flush;

  always_comb begin
    ctrlOut = '0;
    if (doIssue) ctrlOut.issueOh[freeIdx] = 1'b1;
    ctrlOut.dispIdx = RS_IDX_W'(bestIdx);
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      busyNext[i] = busy[i];
      ageNext[i]  = age[i];
      if (flush) begin
        busyNext[i] = 1'b0;
        ageNext[i]  = '0;
      end else if (ctrlOut.issueOh[i]) begin
        busyNext[i] = 1'b1;
        ageNext[i]  = '0;
      end else if (fire && IDX_W'(i) == bestIdx) begin
        busyNext[i] = 1'b0;
        ageNext[i]  = '0;
      end else if (busy[i]) begin
        ageNext[i] = age[i] + AGE_W'(doIssue)
                   - AGE_W'(fire && age[i] > bestAge);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= '0;
      for (int i = 0; i < ENTRIES; i++) age[i] <= '0;
    end else begin
      busy <= busyNext;
      for (int i = 0; i < ENTRIES; i++) age[i] <= ageNext[i];
    end
  end
endmodule

// File: rtl/rsData.sv
module rsData
  import rsPkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int OP_W    = 4,
  parameter int DATA_W  = 16,
  parameter int TAG_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  rsCtrlT             ctrlIn,
  input  logic [OP_W-1:0]    issueOp,
  input  logic [TAG_W-1:0]   issueTagA,
  input  logic [DATA_W-1:0]  issueValA,
  input  logic [TAG_W-1:0]   issueTagB,
  input  logic [DATA_W-1:0]  issueValB,
  input  logic [TAG_W-1:0]   issueDest,
  input  logic               busValid,
  input  logic [TAG_W-1:0]   busTag,
  input  logic [DATA_W-1:0]  busVal,
  output logic [ENTRIES-1:0] readyVec,
  output logic [OP_W-1:0]    dispOp,
  output logic [DATA_W-1:0]  dispValA,
  output logic [DATA_W-1:0]  dispValB,
  output logic [TAG_W-1:0]   dispDest
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [OP_W-1:0]   opQ  [ENTRIES];
  logic [DATA_W-1:0] valA [ENTRIES];
  logic [DATA_W-1:0] valB [ENTRIES];
  logic [TAG_W-1:0]  tagA [ENTRIES];
  logic [TAG_W-1:0]  tagB [ENTRIES];
  logic [TAG_W-1:0]  dest [ENTRIES];
  logic              busLive, newHitA, newHitB, unusedBits;
  logic [IDX_W-1:0]  selIdx;

  assign busLive = busValid && (busTag != '0);
  assign newHitA = busLive && (issueTagA == busTag);
  assign newHitB = busLive && (issueTagB == busTag);
  assign selIdx  = ctrlIn.dispIdx[IDX_W-1:0];
  assign unusedBits = ^{ctrlIn.issueOh, ctrlIn.dispIdx};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        opQ[i]  <= '0;
        valA[i] <= '0;
        valB[i] <= '0;
        tagA[i] <= '0;
        tagB[i] <= '0;
        dest[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (ctrlIn.issueOh[i]) begin
          opQ[i]  <= issueOp;
          dest[i] <= issueDest;
          tagA[i] <= newHitA ? '0 : issueTagA;
          valA[i] <= newHitA ? busVal : issueValA;
          tagB[i] <= newHitB ? '0 : issueTagB;
          valB[i] <= newHitB ? busVal : issueValB;
        end else begin
          if (busLive && tagA[i] == busTag) begin
            tagA[i] <= '0;
            valA[i] <= busVal;
          end
          if (busLive && tagB[i] == busTag) begin
            tagB[i] <= '0;
            valB[i] <= busVal;
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      readyVec[i] = (tagA[i] == '0) && (tagB[i] == '0);
  end

  assign dispOp   = opQ[selIdx];
  assign dispValA = valA[selIdx];
  assign dispValB = valB[selIdx];
  assign dispDest = dest[selIdx];
endmodule

// File: rtl/rsBank.sv
module rsBank
  import rsPkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int OP_W    = 4,
  parameter int DATA_W  = 16,
  parameter int TAG_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              issueValid,
  input  logic [OP_W-1:0]   issueOp,
  input  logic [TAG_W-1:0]  issueTagA,
  input  logic [DATA_W-1:0] issueValA,
  input  logic [TAG_W-1:0]  issueTagB,
  input  logic [DATA_W-1:0] issueValB,
  input  logic [TAG_W-1:0]  issueDest,
  output logic              issueFull,
  input  logic              busValid,
  input  logic [TAG_W-1:0]  busTag,
  input  logic [DATA_W-1:0] busVal,
  output logic              dispValid,
  input  logic              dispReady,
  output logic [OP_W-1:0]   dispOp,
  output logic [DATA_W-1:0] dispValA,
  output logic [DATA_W-1:0] dispValB,
  output logic [TAG_W-1:0]  dispDest
);
  rsCtrlT             ctrlBus;
  logic [ENTRIES-1:0] readyVec;

  rsCtrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush), .issueValid(issueValid),
    .dispReady(dispReady), .readyVec(readyVec), .issueFull(issueFull),
    .dispValid(dispValid), .ctrlOut(ctrlBus)
  );

  rsData #(.ENTRIES(ENTRIES), .OP_W(OP_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_data (
    .clk(clk), .rstN(rstN), .ctrlIn(ctrlBus),
    .issueOp(issueOp), .issueTagA(issueTagA), .issueValA(issueValA),
    .issueTagB(issueTagB), .issueValB(issueValB), .issueDest(issueDest),
    .busValid(busValid), .busTag(busTag), .busVal(busVal),
    .readyVec(readyVec), .dispOp(dispOp), .dispValA(dispValA),
    .dispValB(dispValB), .dispDest(dispDest)
  );
endmodule

// File: rtl/rsBankChk.sv
module rsBankChk
  import rsPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              flush,
  input logic              issueValid,
  input logic              issueFull,
  input logic              dispValid,
  input logic              dispReady,
  input logic [RS_MAX-1:0] issueOh
);
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (!dispValid && !issueFull)); // R1

  AST_FULL_DROPS_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    issueFull |-> (issueOh == '0)); // R6

  AST_ONE_SLOT_PER_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> $onehot0(issueOh)); // R6

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && !dispReady && !flush) |=> dispValid); // R9

  AST_ACCEPT_FREES: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && dispReady && !flush) |=> !issueFull); // R9
endmodule

bind rsBank rsBankChk u_chk (
  .clk(clk), .rstN(rstN), .flush(flush), .issueValid(issueValid),
  .issueFull(issueFull), .dispValid(dispValid), .dispReady(dispReady),
  .issueOh(ctrlBus.issueOh)
);

// File: tb/rsBank_test.sv
module rsBank_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        issueValid = 1'b0;
  logic [3:0]  issueOp = '0;
  logic [3:0]  issueTagA = '0;
  logic [15:0] issueValA = '0;
  logic [3:0]  issueTagB = '0;
  logic [15:0] issueValB = '0;
  logic [3:0]  issueDest = '0;
  logic        issueFull;
  logic        busValid = 1'b0;
  logic [3:0]  busTag = '0;
  logic [15:0] busVal = '0;
  logic        dispValid;
  logic        dispReady = 1'b0;
  logic [3:0]  dispOp;
  logic [15:0] dispValA, dispValB;
  logic [3:0]  dispDest;

  typedef struct packed {
    logic [3:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    logic [3:0]  dst;
  } expT;

  expT expQ[$];
  int  checks = 0;
  int  fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  rsBank uut (
    .clk(clk), .rstN(rstN), .flush(flush), .issueValid(issueValid),
    .issueOp(issueOp), .issueTagA(issueTagA), .issueValA(issueValA),
    .issueTagB(issueTagB), .issueValB(issueValB), .issueDest(issueDest),
    .issueFull(issueFull), .busValid(busValid), .busTag(busTag),
    .busVal(busVal), .dispValid(dispValid), .dispReady(dispReady),
    .dispOp(dispOp), .dispValA(dispValA), .dispValB(dispValB),
    .dispDest(dispDest)
  );

  // monitor: every accepted dispatch is compared with the scoreboard head
  always @(negedge clk) begin
    if (rstN && dispValid && dispReady && !flush) begin
      expT got, exp;
      got = '{dispOp, dispValA, dispValB, dispDest};
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL dispatch R2/R7: unexpected op=%h a=%h b=%h dst=%h, expected none",
                 dispOp, dispValA, dispValB, dispDest);
      end else begin
        exp = expQ.pop_front();
        if (got !== exp) begin
          fails++;
          $display("FAIL dispatch R2/R3/R7/R8: got op=%h a=%h b=%h dst=%h, expected op=%h a=%h b=%h dst=%h",
                   got.op, got.a, got.b, got.dst, exp.op, exp.a, exp.b, exp.dst);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
    issueValid = 1'b0;
    busValid   = 1'b0;
    flush      = 1'b0;
  endtask

  task automatic issue(input logic [3:0] op, input logic [3:0] ta, input logic [15:0] va,
                       input logic [3:0] tb, input logic [15:0] vb, input logic [3:0] dst);
    issueValid = 1'b1;
    issueOp = op; issueTagA = ta; issueValA = va;
    issueTagB = tb; issueValB = vb; issueDest = dst;
  endtask

  task automatic bcast(input logic [3:0] t, input logic [15:0] v);
    busValid = 1'b1; busTag = t; busVal = v;
  endtask

  task automatic expect1(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drain();
    int n;
    n = 0;
    dispReady = 1'b1;
    while (expQ.size() > 0 && n < 20) begin
      step();
      n++;
    end
    dispReady = 1'b0;
  endtask

  task automatic finishRun();
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL scoreboard R2: actual %0d pending expected 0", expQ.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R1 reset state
    expect1("R1 reset full", issueFull, 0);
    expect1("R1 reset dispValid", dispValid, 0);

    // R2 both operands present
    dispReady = 1'b1;
    expQ.push_back('{4'h1, 16'h0010, 16'h0020, 4'h1});
    issue(4'h1, 0, 16'h0010, 0, 16'h0020, 4'h1); step();
    step();
    dispReady = 1'b0;

    // R5 / R3 waiting operand, non-matching then matching broadcast
    issue(4'h2, 4'h3, 16'hdead, 0, 16'h0222, 4'h2); step();
    expect1("R3 waiting not ready", dispValid, 0);
    bcast(4'h7, 16'h7777); step();
    expect1("R5 unmatched tag", dispValid, 0);
    expQ.push_back('{4'h2, 16'h0033, 16'h0222, 4'h2});
    bcast(4'h3, 16'h0033); step();
    expect1("R3 woken", dispValid, 1);
    drain();

    // R4 one broadcast wakes two slots and both operands of one
    issue(4'h3, 4'h4, 0, 4'h4, 0, 4'h3); step();
    issue(4'h4, 4'h5, 0, 0, 16'h0444, 4'h4); step();
    issue(4'h5, 0, 16'h0555, 4'h4, 0, 4'h5); step();
    bcast(4'h4, 16'h0044); step();
    expect1("R4 wake", dispValid, 1);
    expQ.push_back('{4'h3, 16'h0044, 16'h0044, 4'h3});
    expQ.push_back('{4'h5, 16'h0555, 16'h0044, 4'h5});
    drain();
    step();
    expect1("R3 other still waits", dispValid, 0);
    expQ.push_back('{4'h4, 16'h0055, 16'h0444, 4'h4});
    bcast(4'h5, 16'h0055); step();
    drain();

    // R8 issue and matching broadcast in the same cycle
    issue(4'h6, 4'h6, 16'hbad0, 0, 16'h0606, 4'h6);
    bcast(4'h6, 16'h0066); step();
    expect1("R8 same-cycle capture ready", dispValid, 1);
    expQ.push_back('{4'h6, 16'h0066, 16'h0606, 4'h6});
    drain();

    // R7 oldest first, in issue order
    issue(4'h8, 0, 16'h0008, 0, 16'h0080, 4'h8); step();
    issue(4'h9, 0, 16'h0009, 0, 16'h0090, 4'h9); step();
    issue(4'ha, 0, 16'h000a, 0, 16'h00a0, 4'ha); step();
    expQ.push_back('{4'h8, 16'h0008, 16'h0080, 4'h8});
    expQ.push_back('{4'h9, 16'h0009, 16'h0090, 4'h9});
    expQ.push_back('{4'ha, 16'h000a, 16'h00a0, 4'ha});
    drain();
    // R7 older slot ready last still goes first once ready
    issue(4'hb, 4'h9, 0, 0, 16'h00b0, 4'hb); step();
    issue(4'hc, 0, 16'h000c, 0, 16'h00c0, 4'hc); step();
    issue(4'hd, 0, 16'h000d, 0, 16'h00d0, 4'hd); step();
    bcast(4'h9, 16'h0099); step();
    expQ.push_back('{4'hb, 16'h0099, 16'h00b0, 4'hb});
    expQ.push_back('{4'hc, 16'h000c, 16'h00c0, 4'hc});
    expQ.push_back('{4'hd, 16'h000d, 16'h00d0, 4'hd});
    drain();

    // R6 full bank drops an extra issue; R9 release on accept
    for (int k = 1; k <= 4; k++) begin
      issue(4'(k), 0, 16'(k), 0, 16'(k * 16), 4'(k)); step();
      expQ.push_back('{4'(k), 16'(k), 16'(k * 16), 4'(k)});
    end
    expect1("R6 full", issueFull, 1);
    issue(4'hf, 0, 16'hffff, 0, 16'hffff, 4'hf); step();
    expect1("R6 still full", issueFull, 1);
    expect1("R9 offer held", dispValid, 1);
    dispReady = 1'b1; step();
    expect1("R9 freed after accept", issueFull, 0);
    drain();
    step();
    expect1("R6 dropped issue absent", dispValid, 0);

    // R1 flush drops waiting slots
    issue(4'h7, 4'hb, 0, 0, 16'h0007, 4'h7); step();
    issue(4'h7, 4'hc, 0, 0, 16'h0007, 4'h8); step();
    flush = 1'b1; step();
    expect1("R1 flush full", issueFull, 0);
    expect1("R1 flush dispValid", dispValid, 0);
    bcast(4'hb, 16'h1111); step();
    bcast(4'hc, 16'h2222); step();
    expect1("R1 flushed stays empty", dispValid, 0);

    finishRun();
  end
endmodule